// File: doc/BRIEF.md
# Region Data Protection Unit

This block sits between a processor core's data port and the downstream bus interface. It checks every data load or store against four programmable protection regions and one default global region. For each access it decides whether to allow it, and it hands the winning region's attribute bits to the bus side. The whole decision is combinational, so the result appears in the same cycle as the access request.

Software programs the regions through a simple write port. Each region has its own word, holding a size-aligned base, a power-of-two size code, a 2-bit permission and the attribute bits. A separate global word holds the per-region enable bits and the permission and attributes of the global region. When several enabled regions cover an address, the lowest-numbered one wins. When none covers it, the global region applies. A data-relocation enable from the core's machine state gates the whole check: while it is clear, every access is allowed and the global attributes are used.

The checking path holds no state, so the block has no state machine. The only sequential part is the configuration register file.

Top module: `data_prot_unit`

## Requirements
- R1: A write with `cfg_sel` = i (0 to 3) loads region i as follows: base from `cfg_wdata[31:12]`, size code from `[11:8]`, attributes from `[7:4]`, permission from `[1:0]`.
- R2: A write with `cfg_sel` = 4 loads the global word: region enables from `cfg_wdata[3:0]` (bit i enables region i), global permission from `[9:8]`, global attributes from `[15:12]`. Writes with `cfg_sel` of 5 to 7 change nothing.
- R3: After reset every region is disabled, the global permission is 11 and the global attributes are 0.
- R4: A region with size code s covers 2^(12+min(s,12)) bytes, from 4 KB up to 16 MB, so codes 12 to 15 all mean 16 MB. An address matches the region when its bits above that size equal the base's bits above that size.
- R5: A disabled region never matches, whatever the address.
- R6: When several enabled regions match, the lowest-numbered one is the effective region.
- R7: When no enabled region matches, the global permission and attributes are used.
- R8: Permission codes: 00 denies every access; 01 allows supervisor reads and writes only; 10 allows supervisor reads and writes plus user reads; 11 allows all. `acc_user` = 1 marks a user access and `acc_write` = 1 marks a store.
- R9: While `acc_valid` is high and relocation is enabled, exactly one of `acc_grant` and `acc_fault` is high, in the same cycle as the request. While `acc_valid` is low, both are low.
- R10: While `acc_dr_en` is 0, a valid access is always granted, never faults, and `acc_attr` shows the global attributes.
- R11: A configuration write takes effect at the clock edge that captures it. Accesses in the same cycle still see the old settings.
- R12: While `acc_dr_en` is 1, `acc_attr` shows the effective region's attribute bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration word select (0 to 3 regions, 4 global) |
| cfg_wdata | input | 32 | Configuration write data |
| acc_valid | input | 1 | Data access request present |
| acc_addr | input | 32 | Access address |
| acc_write | input | 1 | 1 = store, 0 = load |
| acc_user | input | 1 | 1 = user mode, 0 = supervisor |
| acc_dr_en | input | 1 | Data-relocation enable from machine state |
| acc_grant | output | 1 | Access allowed |
| acc_fault | output | 1 | Protection fault toward the core |
| acc_attr | output | 4 | Attribute bits of the effective region |

## Verification
The assertions take for granted that the access inputs and the configuration strobe hold steady, known values around each rising edge after reset. They also assume that the select lines are stable while `cfg_we` is low, because the unused-select and stability properties sample them at the edge.

The bench changes every input on the falling edge and samples the outputs two nanoseconds later, so the combinational result has settled before the next capturing edge. It sweeps all sixteen enable masks. For each mask it probes the edges of every region, in both privilege modes, for loads and stores, with relocation on and off. Expected results are derived arithmetically from a shadow copy of the words it wrote.

// File: rtl/dpu_pkg.sv
package dpu_pkg;
    localparam int SIZE_W     = 4;
    localparam int PERM_W     = 2;
    // region word field positions
    localparam int R_PERM_LSB = 0;
    localparam int R_ATTR_LSB = 4;
    localparam int R_SIZE_LSB = 8;
    // global word field positions
    localparam int G_EN_LSB   = 0;
    localparam int G_PERM_LSB = 8;
    localparam int G_ATTR_LSB = 12;

    typedef enum logic [PERM_W-1:0] {
        PERM_NONE      = 2'b00,
        PERM_SUP       = 2'b01,
        PERM_SUP_UREAD = 2'b10,
        PERM_ALL       = 2'b11
    } perm_e;
endpackage

// File: rtl/dpu_cfg_regs.sv
module dpu_cfg_regs
    import dpu_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int NREG    = 4,
    parameter int ATTR_W  = 4,
    parameter int MIN_LOG = 12,
    localparam int SEL_W  = $clog2(NREG + 1),
    localparam int BASE_W = ADDR_W - MIN_LOG
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             cfg_we,
    input  logic [SEL_W-1:0]                 cfg_sel,
    input  logic [ADDR_W-1:0]                cfg_wdata,
    output logic [NREG-1:0][BASE_W-1:0]      base_q,
    output logic [NREG-1:0][SIZE_W-1:0]      size_q,
    output logic [NREG-1:0][PERM_W-1:0]      perm_q,
    output logic [NREG-1:0][ATTR_W-1:0]      attr_q,
    output logic [NREG-1:0]                  en_q,
    output logic [PERM_W-1:0]                gperm_q,
    output logic [ATTR_W-1:0]                gattr_q
);
    logic unused_wbits;
    assign unused_wbits = ^cfg_wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q  <= '0;
            size_q  <= '0;
            perm_q  <= '0;
            attr_q  <= '0;
            en_q    <= '0;
            gperm_q <= PERM_ALL;
            gattr_q <= '0;
        end else if (cfg_we) begin
            for (int i = 0; i < NREG; i++) begin
                if (cfg_sel == SEL_W'(i)) begin
                    base_q[i] <= cfg_wdata[ADDR_W-1:MIN_LOG];
                    size_q[i] <= cfg_wdata[R_SIZE_LSB +: SIZE_W];
                    perm_q[i] <= cfg_wdata[R_PERM_LSB +: PERM_W];
                    attr_q[i] <= cfg_wdata[R_ATTR_LSB +: ATTR_W];
                end
            end
            if (cfg_sel == SEL_W'(NREG)) begin
                en_q    <= cfg_wdata[G_EN_LSB +: NREG];
                gperm_q <= cfg_wdata[G_PERM_LSB +: PERM_W];
                gattr_q <= cfg_wdata[G_ATTR_LSB +: ATTR_W];
            end
        end
    end
endmodule

// File: rtl/dpu_region_cmp.sv
module dpu_region_cmp
    import dpu_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int MIN_LOG  = 12,
    parameter int MAX_STEP = 12,
    localparam int BASE_W  = ADDR_W - MIN_LOG
) (
    input  logic [BASE_W-1:0] page,
    input  logic [BASE_W-1:0] base,
    input  logic [SIZE_W-1:0] size_code,
    input  logic              enable,
    output logic              hit
);
    logic [SIZE_W-1:0] step;
    logic [BASE_W-1:0] keep;

    always_comb begin
        step = (size_code > SIZE_W'(MAX_STEP)) ? SIZE_W'(MAX_STEP) : size_code;
        for (int b = 0; b < BASE_W; b++) begin
            keep[b] = (b >= int'(step));
        end
    end

    assign hit = enable && (((page ^ base) & keep) == '0);
endmodule

// File: rtl/dpu_region_pick.sv
module dpu_region_pick
    import dpu_pkg::*;
#(
    parameter int NREG   = 4,
    parameter int ATTR_W = 4
) (
    input  logic [NREG-1:0]              hit_vec,
    input  logic [NREG-1:0][PERM_W-1:0]  perm_q,
    input  logic [NREG-1:0][ATTR_W-1:0]  attr_q,
    input  logic [PERM_W-1:0]            gperm,
    input  logic [ATTR_W-1:0]            gattr,
    output logic [NREG-1:0]              sel_oh,
    output logic [PERM_W-1:0]            eff_perm,
    output logic [ATTR_W-1:0]            eff_attr
);
    always_comb begin
        sel_oh   = '0;
        eff_perm = gperm;
        eff_attr = gattr;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                sel_oh    = '0;
                sel_oh[i] = 1'b1;
                eff_perm  = perm_q[i];
                eff_attr  = attr_q[i];
            end
        end
    end
endmodule

// File: rtl/dpu_perm_chk.sv
module dpu_perm_chk
    import dpu_pkg::*;
(
    input  logic [PERM_W-1:0] perm,
    input  logic              is_write,
    input  logic              is_user,
    output logic              ok
);
    always_comb begin
        unique case (perm_e'(perm))
            PERM_NONE:      ok = 1'b0;
            PERM_SUP:       ok = !is_user;
            PERM_SUP_UREAD: ok = !is_user || !is_write;
            PERM_ALL:       ok = 1'b1;
            default:        ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/data_prot_unit.sv
module data_prot_unit
    import dpu_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int NREG     = 4,
    parameter int ATTR_W   = 4,
    parameter int MIN_LOG  = 12,
    parameter int MAX_STEP = 12,
    localparam int SEL_W   = $clog2(NREG + 1),
    localparam int BASE_W  = ADDR_W - MIN_LOG
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_write,
    input  logic              acc_user,
    input  logic              acc_dr_en,
    output logic              acc_grant,
    output logic              acc_fault,
    output logic [ATTR_W-1:0] acc_attr
);
    logic [NREG-1:0][BASE_W-1:0] base_q;
    logic [NREG-1:0][SIZE_W-1:0] size_q;
    logic [NREG-1:0][PERM_W-1:0] perm_q;
    logic [NREG-1:0][ATTR_W-1:0] attr_q;
    logic [NREG-1:0]             en_q;
    logic [PERM_W-1:0]           gperm_q;
    logic [ATTR_W-1:0]           gattr_q;
    logic [NREG-1:0]             hit_vec;
    logic [NREG-1:0]             sel_oh;
    logic [PERM_W-1:0]           eff_perm;
    logic [ATTR_W-1:0]           eff_attr;
    logic                        perm_ok;
    logic                        unused_low;

    assign unused_low = ^acc_addr[MIN_LOG-1:0];

    dpu_cfg_regs #(
        .ADDR_W(ADDR_W), .NREG(NREG), .ATTR_W(ATTR_W), .MIN_LOG(MIN_LOG)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .base_q(base_q), .size_q(size_q),
        .perm_q(perm_q), .attr_q(attr_q), .en_q(en_q),
        .gperm_q(gperm_q), .gattr_q(gattr_q)
    );

    for (genvar g = 0; g < NREG; g++) begin : g_cmp
        dpu_region_cmp #(
            .ADDR_W(ADDR_W), .MIN_LOG(MIN_LOG), .MAX_STEP(MAX_STEP)
        ) u_cmp (
            .page(acc_addr[ADDR_W-1:MIN_LOG]), .base(base_q[g]),
            .size_code(size_q[g]), .enable(en_q[g]), .hit(hit_vec[g])
        );
    end

    dpu_region_pick #(.NREG(NREG), .ATTR_W(ATTR_W)) u_pick (
        .hit_vec(hit_vec), .perm_q(perm_q), .attr_q(attr_q),
        .gperm(gperm_q), .gattr(gattr_q), .sel_oh(sel_oh),
        .eff_perm(eff_perm), .eff_attr(eff_attr)
    );

    dpu_perm_chk u_perm (
        .perm(eff_perm), .is_write(acc_write), .is_user(acc_user), .ok(perm_ok)
    );

    always_comb begin
        if (!acc_dr_en) begin
            acc_grant = acc_valid;
            acc_fault = 1'b0;
            acc_attr  = gattr_q;
        end else begin
            acc_grant = acc_valid && perm_ok;
            acc_fault = acc_valid && !perm_ok;
            acc_attr  = eff_attr;
        end
    end
endmodule

// File: rtl/dpu_checker.sv
module dpu_checker #(
    parameter int NREG   = 4,
    parameter int ATTR_W = 4,
    parameter int SEL_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [SEL_W-1:0]  cfg_sel,
    input logic              acc_valid,
    input logic              acc_dr_en,
    input logic              acc_grant,
    input logic              acc_fault,
    input logic [ATTR_W-1:0] acc_attr,
    input logic [NREG-1:0]   hit_vec,
    input logic [NREG-1:0]   sel_oh,
    input logic [ATTR_W-1:0] gattr_q
);
    // R9
    grant_fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_dr_en) |-> (acc_grant != acc_fault));
    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> (!acc_grant && !acc_fault));
    // R10
    bypass_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_dr_en) |-> (acc_grant && acc_attr == gattr_q));
    // R6
    single_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_oh));
    // R6
    winner_is_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_vec != '0) |-> ((sel_oh & ~hit_vec) == '0 && sel_oh != '0));
    // R7
    global_fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_dr_en && hit_vec == '0) |-> (acc_attr == gattr_q && sel_oh == '0));
    // R2
    global_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we || cfg_sel != SEL_W'(NREG)) |=> $stable(gattr_q));
endmodule

bind data_prot_unit dpu_checker #(
    .NREG(NREG), .ATTR_W(ATTR_W), .SEL_W(SEL_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .acc_valid(acc_valid), .acc_dr_en(acc_dr_en), .acc_grant(acc_grant),
    .acc_fault(acc_fault), .acc_attr(acc_attr), .hit_vec(hit_vec),
    .sel_oh(sel_oh), .gattr_q(gattr_q)
);

// File: tb/data_prot_unit_tb.sv
module data_prot_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        acc_write = 1'b0;
    logic        acc_user = 1'b0;
    logic        acc_dr_en = 1'b0;
    logic        acc_grant;
    logic        acc_fault;
    logic [3:0]  acc_attr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] sh_base [4];
    logic [3:0]  sh_code [4];
    logic [3:0]  sh_attr [4];
    logic [1:0]  sh_perm [4];
    logic [3:0]  sh_en;
    logic [1:0]  sh_gperm;
    logic [3:0]  sh_gattr;

    always #4 clk = ~clk;

    data_prot_unit u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_write(acc_write), .acc_user(acc_user), .acc_dr_en(acc_dr_en),
        .acc_grant(acc_grant), .acc_fault(acc_fault), .acc_attr(acc_attr)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s addr=%h got %h expected %h", tag, what, acc_addr, got, exp);
        end
    endtask

    function automatic int size_log(input logic [3:0] code);
        return 12 + ((code > 4'd12) ? 12 : int'(code));
    endfunction

    function automatic void shadow_write(input logic [2:0] sel, input logic [31:0] d);
        if (sel < 3'd4) begin
            sh_base[sel[1:0]] = d & 32'hFFFF_F000;
            sh_code[sel[1:0]] = d[11:8];
            sh_attr[sel[1:0]] = d[7:4];
            sh_perm[sel[1:0]] = d[1:0];
        end else if (sel == 3'd4) begin
            sh_en    = d[3:0];
            sh_gperm = d[9:8];
            sh_gattr = d[15:12];
        end
    endfunction

    function automatic void model(input logic [31:0] a, input logic w, input logic u,
                                  input logic dr, input logic v, output logic eg,
                                  output logic ef, output logic [3:0] ea);
        int win = -1;
        logic [1:0] p;
        logic [3:0] at;
        logic ok;
        for (int i = 3; i >= 0; i--) begin
            int lg = size_log(sh_code[i]);
            if (sh_en[i] && ((a >> lg) == (sh_base[i] >> lg))) win = i;
        end
        p  = (win >= 0) ? sh_perm[win] : sh_gperm;
        at = (win >= 0) ? sh_attr[win] : sh_gattr;
        case (p)
            2'd0:    ok = 1'b0;
            2'd1:    ok = !u;
            2'd2:    ok = !u || !w;
            default: ok = 1'b1;
        endcase
        if (!dr) begin
            eg = v; ef = 1'b0; ea = sh_gattr;
        end else begin
            eg = v && ok; ef = v && !ok; ea = at;
        end
    endfunction

    function automatic logic [31:0] probe(input int k);
        logic [31:0] sz, b;
        if (k >= 16) return (k == 16) ? 32'h0 : 32'hFFFF_F123;
        sz = 32'd1 << size_log(sh_code[k / 4]);
        b  = sh_base[k / 4] & ~(sz - 1);
        case (k % 4)
            0:       return b - 1;
            1:       return b;
            2:       return b + sz - 1;
            default: return b + sz;
        endcase
    endfunction

    task automatic write_cfg(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        shadow_write(sel, d);
    endtask

    task automatic access(input string tag, input logic [31:0] a, input logic w,
                          input logic u, input logic dr, input logic v);
        logic eg, ef;
        logic [3:0] ea;
        @(negedge clk);
        acc_addr = a; acc_write = w; acc_user = u; acc_dr_en = dr; acc_valid = v;
        #2;
        model(a, w, u, dr, v, eg, ef, ea);
        chk(tag, "grant", 32'(acc_grant), 32'(eg));
        chk(tag, "fault", 32'(acc_fault), 32'(ef));
        chk(tag, "attr", 32'(acc_attr), 32'(ea));
    endtask

    task automatic sweep(input string tag);
        for (int k = 0; k < 18; k++) begin
            for (int m = 0; m < 8; m++) begin
                access(tag, probe(k), m[0], m[1], m[2], 1'b1);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic eg, ef;
        logic [3:0] ea;
        for (int i = 0; i < 4; i++) shadow_write(3'(i), 32'h0);
        shadow_write(3'd4, 32'h0000_0300);

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R3: quiet outputs during reset
        chk("R3", "grant in reset", 32'(acc_grant), 32'd0);
        chk("R3", "fault in reset", 32'(acc_fault), 32'd0);
        rst_n = 1'b1;

        // R3: reset configuration grants everything with attribute 0
        sweep("R3");
        // R9: no request means no grant and no fault
        access("R9 idle", 32'h0001_0000, 1'b1, 1'b1, 1'b1, 1'b0);

        // R1: program overlapping regions; R4: region 3 uses clamped size code
        write_cfg(3'd0, 32'h0001_0010);
        write_cfg(3'd1, 32'h0001_0422);
        write_cfg(3'd2, 32'h0000_0831);
        write_cfg(3'd3, 32'h0100_0F43);

        // R2 R4 R5 R6 R7 R8 R10 R12: every enable mask
        for (int mask = 0; mask < 16; mask++) begin
            write_cfg(3'd4, 32'h0000_5200 | 32'(mask));
            sweep("R1 R4 R5 R6 R7 R8 R10 R12 mask sweep");
        end

        // R2: unused selects leave all settings unchanged
        write_cfg(3'd5, 32'hFFFF_FFFF);
        write_cfg(3'd6, 32'hFFFF_FFFF);
        write_cfg(3'd7, 32'hFFFF_FFFF);
        sweep("R2 unused select");

        // R11: write is invisible in its own cycle, visible after the edge
        write_cfg(3'd4, 32'h0000_5201);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 3'd0; cfg_wdata = 32'h3000_0093;
        acc_addr = 32'h3000_0010; acc_write = 1'b1; acc_user = 1'b1;
        acc_dr_en = 1'b1; acc_valid = 1'b1;
        #2;
        model(acc_addr, 1'b1, 1'b1, 1'b1, 1'b1, eg, ef, ea);
        chk("R11 before edge", "fault", 32'(acc_fault), 32'(ef));
        chk("R11 before edge", "attr", 32'(acc_attr), 32'(ea));
        @(negedge clk);
        cfg_we = 1'b0;
        shadow_write(3'd0, 32'h3000_0093);
        #2;
        model(acc_addr, 1'b1, 1'b1, 1'b1, 1'b1, eg, ef, ea);
        chk("R11 after edge", "grant", 32'(acc_grant), 32'(eg));
        chk("R11 after edge", "attr", 32'(acc_attr), 32'(ea));

        // R8: every permission code against every mode and direction
        for (int p = 0; p < 4; p++) begin
            write_cfg(3'd0, 32'h2000_0000 | 32'(p << 4) | 32'(p));
            for (int m = 0; m < 4; m++) begin
                access("R8 permission", 32'h2000_0ABC, m[0], m[1], 1'b1, 1'b1);
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule